// File: doc/BRIEF.md
# Synchronous parallel bit-bang engine

This block ties a narrow parallel I/O port to a byte stream. Each byte taken from the receive side starts one fixed transaction. The block samples the pins as they stand before anything changes and hands that sample to the transmit side. It then drives the byte onto the bits enabled as outputs, waits one setup cycle, and pulses a write strobe. Two active-low strobes let logic outside the block follow the read and write phases. Because of this ordering, every returned sample shows the port state from before the byte that caused it.

Each bit's direction comes from a mask. A configuration handshake loads the mask, and the block accepts it only while no transaction is in progress. A loaded mask reaches the output enables when the next byte is driven. The mask then stays in force until the next load. Bits with a mask bit of 0 are tri-stated, but they are still sampled. A port configured as all inputs still needs bytes on the receive side to produce reads. When the transmit side applies back-pressure, the block waits in the sample phase with all its outputs frozen.

Top module: `bb_engine`

## Requirements
- R1: While rst_ni is low and after its release: pin_oe_o = 0, pin_o = 0, rd_stb_no = 1, wr_stb_no = 1, tx_valid_o = 0, and rx_ready_o = 1 unless cfg_valid_i is high.
- R2: On the clock edge where a receive byte is accepted (rx_valid_i and rx_ready_o both high), pin_i is captured. From the next cycle, tx_data_o carries that capture. The capture does not include the byte being accepted.
- R3: From the accept edge until the transmit handshake edge (tx_valid_o and tx_ready_i both high), rd_stb_no is 0 and tx_valid_o is 1. On the handshake edge, rd_stb_no rises and tx_valid_o falls.
- R4: On the same edge where rd_stb_no rises, pin_o becomes the accepted byte AND the active mask, and pin_oe_o becomes the active mask. pin_o and pin_oe_o change on no other edge.
- R5: wr_stb_no goes low exactly one clock after rd_stb_no rises. It stays low for exactly one cycle. rx_ready_o returns one cycle after that.
- R6: While tx_valid_o is 1 and tx_ready_i is 0, tx_data_o, pin_o, pin_oe_o and both strobes hold their values.
- R7: rx_ready_o is 0 from the accept edge until the transaction has finished. No second byte is accepted during a transaction.
- R8: cfg_ready_o is 1 only when the block is idle. When cfg_valid_i is high in idle, the mask is loaded and rx_ready_o is 0 in that cycle. A loaded mask changes pin_oe_o only when the next byte is driven (R4). A mask offered while the block is busy is ignored.
- R9: Bits with a mask bit of 0 have pin_oe_o = 0 and pin_o = 0, whatever the written byte holds. These bits are still sampled per R2.
- R10: With an all-zero mask, every accepted byte still gives one read (R2, R3) and one write strobe (R5), and pin_oe_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Direction mask offered |
| cfg_mask_i | input | W | Direction mask, 1 = output |
| cfg_ready_o | output | 1 | Mask accepted this cycle (idle) |
| rx_valid_i | input | 1 | Receive byte available |
| rx_data_i | input | W | Receive byte |
| rx_ready_o | output | 1 | Receive byte is taken this cycle |
| tx_valid_o | output | 1 | Sample available |
| tx_data_o | output | W | Sampled pin state |
| tx_ready_i | input | 1 | Transmit side takes the sample |
| pin_i | input | W | Pin state as seen at the pads |
| pin_o | output | W | Pin output data |
| pin_oe_o | output | W | Per-bit output enable |
| rd_stb_no | output | 1 | Read strobe, active low |
| wr_stb_no | output | 1 | Write strobe, active low |

## Verification
The bench builds the engine with W = 4. At that width, every one of the 16 masks can be paired with every one of the 16 data values. This covers each tri-state pattern, including the all-input and all-output cases, with every combination of driven and ignored bits. A loopback drives the masked-off pins from a pattern that differs from the written data. This shows that a sample returns the pre-transaction port and never the new byte. Extended transmit stalls, and masks offered while the block is busy, test the freeze and the idle-only loading.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SETUP  = 2'd2,
    ST_STROBE = 2'd3
  } bb_state_e;
endpackage

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_valid_i,
  input  logic rx_valid_i,
  input  logic tx_ready_i,
  output logic cfg_ready_o,
  output logic cfg_we_o,
  output logic rx_ready_o,
  output logic pop_o,
  output logic load_o,
  output logic idle_o,
  output logic tx_valid_o,
  output logic rd_stb_no,
  output logic wr_stb_no
);
  bb_state_e state_q, state_d;

  assign idle_o      = (state_q == ST_IDLE);
  assign cfg_ready_o = idle_o;
  assign cfg_we_o    = idle_o & cfg_valid_i;
  // setup has priority over data in idle
  assign rx_ready_o  = idle_o & ~cfg_valid_i;
  assign pop_o       = rx_ready_o & rx_valid_i;
  assign tx_valid_o  = (state_q == ST_SAMPLE);
  assign load_o      = tx_valid_o & tx_ready_i;
  assign rd_stb_no   = ~(state_q == ST_SAMPLE);
  assign wr_stb_no   = ~(state_q == ST_STROBE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (pop_o)  state_d = ST_SAMPLE;
      ST_SAMPLE: if (load_o) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R3
  rd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i) |=> (rd_stb_no && !tx_valid_o));
  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_stb_no) |=> (!wr_stb_no ##1 (wr_stb_no && rx_ready_o == !cfg_valid_i)));
  // R7
  no_double_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o) |=> (!rx_ready_o && !rd_stb_no));
  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && !rd_stb_no && wr_stb_no));
endmodule

// File: rtl/bb_dir_ctrl.sv
module bb_dir_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [W-1:0] cfg_mask_i,
  input  logic         idle_i,
  input  logic         load_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] mask_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      oe_q   <= '0;
    end else begin
      if (cfg_we_i) mask_q <= cfg_mask_i;
      if (load_i)   oe_q   <= mask_q;
    end
  end

  assign mask_o = mask_q;
  assign oe_o   = oe_q;

  // R8
  cfg_idle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> idle_i);
  // R4
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(oe_o));
endmodule

// File: rtl/bb_port_drv.sv
module bb_port_drv #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pop_i,
  input  logic         load_i,
  input  logic [W-1:0] rx_data_i,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] sample_o,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] hold_q, sample_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      sample_q <= '0;
      out_q    <= '0;
    end else begin
      if (pop_i) begin
        hold_q   <= rx_data_i;
        sample_q <= pin_i;
      end
      if (load_i) out_q <= hold_q & mask_i;
    end
  end

  assign sample_o = sample_q;
  assign pin_o    = out_q;

  // R2
  sample_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> (sample_o == $past(pin_i)));
  // R4
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(pin_o));
endmodule

// File: rtl/bb_engine.sv
module bb_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_valid_i,
  input  logic [W-1:0] cfg_mask_i,
  output logic         cfg_ready_o,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  output logic         rx_ready_o,
  output logic         tx_valid_o,
  output logic [W-1:0] tx_data_o,
  input  logic         tx_ready_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic         rd_stb_no,
  output logic         wr_stb_no
);
  logic cfg_we, pop, load, idle;
  logic [W-1:0] mask;

  bb_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_valid_i (cfg_valid_i),
    .rx_valid_i  (rx_valid_i),
    .tx_ready_i  (tx_ready_i),
    .cfg_ready_o (cfg_ready_o),
    .cfg_we_o    (cfg_we),
    .rx_ready_o  (rx_ready_o),
    .pop_o       (pop),
    .load_o      (load),
    .idle_o      (idle),
    .tx_valid_o  (tx_valid_o),
    .rd_stb_no   (rd_stb_no),
    .wr_stb_no   (wr_stb_no)
  );

  bb_dir_ctrl #(.W(W)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we),
    .cfg_mask_i (cfg_mask_i),
    .idle_i     (idle),
    .load_i     (load),
    .mask_o     (mask),
    .oe_o       (pin_oe_o)
  );

  bb_port_drv #(.W(W)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pop_i     (pop),
    .load_i    (load),
    .rx_data_i (rx_data_i),
    .pin_i     (pin_i),
    .mask_i    (mask),
    .sample_o  (tx_data_o),
    .pin_o     (pin_o)
  );

  // R9
  masked_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0);
  // R6
  stall_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> ($stable(tx_data_o) && $stable(pin_o) && $stable(pin_oe_o)));
endmodule

// File: tb/bb_engine_bench.sv
`timescale 1ns/1ps
module bb_engine_bench;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [W-1:0] cfg_mask = '0;
  logic cfg_ready;
  logic rx_valid = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic rx_ready;
  logic tx_valid;
  logic [W-1:0] tx_data;
  logic tx_ready = 1'b0;
  logic [W-1:0] pin_in, pin_out, pin_oe;
  logic rd_n, wr_n;
  logic [W-1:0] ext = '0;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_out = '0;
  logic [W-1:0] exp_oe = '0;
  logic [W-1:0] cur_mask = '0;

  always #2.5 clk = ~clk;

  assign pin_in = (pin_out & pin_oe) | (ext & ~pin_oe);

  bb_engine #(.W(W)) u_bb_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_mask_i(cfg_mask), .cfg_ready_o(cfg_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .rd_stb_no(rd_n), .wr_stb_no(wr_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic load_mask(input logic [W-1:0] m, input logic with_rx);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_mask  = m;
    rx_valid  = with_rx;
    #0.1;
    check("R8 cfg_ready in idle", int'(cfg_ready), 1);
    check("R8 rx_ready low under cfg", int'(rx_ready), 0);
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    rx_valid  = 1'b0;
    cur_mask  = m;
    check("R8 oe unchanged after load", int'(pin_oe), int'(exp_oe));
    check("R7 no pop under cfg", int'(rd_n), 1);
  endtask

  task automatic do_byte(input logic [W-1:0] d, input int stall, input logic busy_cfg);
    logic [W-1:0] exp_smp;
    @(negedge clk);
    exp_smp = (exp_out & exp_oe) | (ext & ~exp_oe);
    rx_valid = 1'b1;
    rx_data  = d;
    tx_ready = (stall == 0);
    #0.1;
    check("R7 rx_ready idle", int'(rx_ready), 1);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = ~d;
    ext      = ~ext;
    check("R3 rd low after pop", int'(rd_n), 0);
    check("R3 tx_valid", int'(tx_valid), 1);
    check("R2 sample pre-write", int'(tx_data), int'(exp_smp));
    check("R4 pin_o old", int'(pin_out), int'(exp_out));
    check("R7 rx_ready busy", int'(rx_ready), 0);
    for (int i = 0; i < stall; i++) begin
      if (busy_cfg) begin
        cfg_valid = 1'b1;
        cfg_mask  = ~cur_mask;
      end
      rx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R8 cfg_ready busy", int'(cfg_ready), 0);
      check("R6 rd held", int'(rd_n), 0);
      check("R6 sample held", int'(tx_data), int'(exp_smp));
      check("R6 pin_o held", int'(pin_out), int'(exp_out));
      check("R6 oe held", int'(pin_oe), int'(exp_oe));
      check("R7 no pop in stall", int'(rx_ready), 0);
    end
    cfg_valid = 1'b0;
    rx_valid  = 1'b0;
    tx_ready  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_ready = 1'b0;
    exp_out  = d & cur_mask;
    exp_oe   = cur_mask;
    check("R3 rd rises", int'(rd_n), 1);
    check("R3 tx_valid drops", int'(tx_valid), 0);
    check("R4 R9 pin_o", int'(pin_out), int'(exp_out));
    check("R4 R10 oe", int'(pin_oe), int'(exp_oe));
    check("R5 wr still high", int'(wr_n), 1);
    @(posedge clk);
    @(negedge clk);
    check("R5 wr low", int'(wr_n), 0);
    check("R5 not idle yet", int'(rx_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R5 wr back high", int'(wr_n), 1);
    check("R5 idle again", int'(rx_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe reset", int'(pin_oe), 0);
    check("R1 pin_o reset", int'(pin_out), 0);
    check("R1 rd reset", int'(rd_n), 1);
    check("R1 wr reset", int'(wr_n), 1);
    check("R1 tx_valid reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rx_ready after reset", int'(rx_ready), 1);
    check("R1 oe after reset", int'(pin_oe), 0);

    // all-input port still reads on each byte
    ext = 4'h9;
    do_byte(4'hF, 0, 1'b0);
    check("R10 all-input oe", int'(pin_oe), 0);

    for (int m = 0; m < N; m++) begin
      load_mask(m[W-1:0], m[0]);
      for (int d = 0; d < N; d++) begin
        ext = 4'(d * 5 + m * 3 + 1);
        do_byte(d[W-1:0], (d == 7) ? 3 : ((d == 12) ? 1 : 0), (d == 7));
      end
    end
    finish_run();
  end
endmodule